// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the eight-bit status register of a small processor core. It keeps the arithmetic result flags, a single bit-copy storage bit and the global interrupt enable. When the execution stage requests an update, the block adds or subtracts the two 8-bit operands itself and derives half carry, overflow, negative, zero and carry from the result. For a logic operation it takes the result from the ALU and derives only the sign-related and zero flags.

Around the register sit the interrupt controls. There are set-enable and clear-enable commands. A return-from-interrupt command sets the enable again. An accepted interrupt clears the enable in hardware, and that clear takes priority over any other update of the enable in the same cycle. The current enable gates each pending interrupt source together with that source's own enable. Two bit-copy paths move one selected bit between a register operand and the storage bit: one copies the operand bit into the storage bit, the other writes the storage bit into the operand. Software can write the whole register in one cycle.

Top module: `proc_status_reg`

## Requirements
- R1: The status register `status_o` holds I at bit 7, T at bit 6, H at bit 5, S at bit 4, V at bit 3, N at bit 2, Z at bit 1 and C at bit 0, and all eight bits are 0 after reset.
- R2: With `wr_en_i` high, every bit of `wr_data_i` except S is stored at the next clock edge. The stored S is the XOR of the written N and V.
- R3: S always equals N XOR V, including after every arithmetic, logic or software update.
- R4: `alu_op_i` uses 0 for no update, 1 for add, 2 for subtract and 3 for logic. For add, C is the carry out of bit 7 and H is the carry out of bit 3. V is set when both operands have the same sign and the result sign differs from it. N is result bit 7 and Z is set for a zero result. I and T are unchanged.
- R5: For subtract (`opa_i - opb_i`), C is the borrow out of bit 7 and H is the borrow out of bit 3. V is set when the operand signs differ and the result sign differs from the minuend sign. N and Z follow the result.
- R6: For a logic operation on `logic_res_i`, V is cleared, N and Z follow that result, and C, H, I and T keep their values.
- R7: `irq_req_o[k]` is `irq_pend_i[k] & irq_en_i[k]` when I is 1, and all request outputs are 0 when I is 0, whatever the source enables are.
- R8: `sei_i` sets I and `cli_i` clears I at the next edge. If both are high in the same cycle, the clear wins.
- R9: `irq_ack_i` clears I at the next edge, and `reti_i` sets I.
- R10: When `irq_ack_i` is high in the same cycle as `sei_i`, `reti_i` or a software write with I set, I ends up 0.
- R11: `bst_i` copies bit `bit_sel_i` (0 to 7) of `reg_op_i` into T at the next edge.
- R12: `bld_res_o` equals `reg_op_i` with bit `bit_sel_i` replaced by T. All other bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alu_op_i | input | 2 | Flag update request: 0 none, 1 add, 2 subtract, 3 logic |
| opa_i | input | 8 | First operand, minuend for subtract |
| opb_i | input | 8 | Second operand, subtrahend for subtract |
| logic_res_i | input | 8 | Result of a logic operation from the ALU |
| arith_res_o | output | 8 | Sum or difference of the operands |
| wr_en_i | input | 1 | Whole-register software write strobe |
| wr_data_i | input | 8 | Software write value |
| sei_i | input | 1 | Set global interrupt enable |
| cli_i | input | 1 | Clear global interrupt enable |
| reti_i | input | 1 | Return from interrupt, sets the enable |
| irq_ack_i | input | 1 | Interrupt accepted, clears the enable |
| bst_i | input | 1 | Copy selected operand bit into T |
| bit_sel_i | input | 3 | Bit index for the bit-copy paths |
| reg_op_i | input | 8 | Register operand for the bit-copy paths |
| bld_res_o | output | 8 | Operand with T inserted at the selected bit |
| irq_pend_i | input | 4 | Pending interrupt sources |
| irq_en_i | input | 4 | Per-source interrupt enables |
| irq_req_o | output | 4 | Gated interrupt requests |
| status_o | output | 8 | Current status register |

## Verification
The flag logic is driven with add operands chosen to tell each flag apart. A low-nibble carry with no byte carry sets H alone. A signed overflow into a negative result sets N and V but leaves S at 0. A wrap to zero produces carry and zero without overflow. Two negative operands produce overflow with S set. Subtract cases separate a borrow in both the nibble and the byte, a nibble borrow alone, an equal-operand zero, and an overflow that comes from a negative minuend. Logic cases start from preset values with C, H and V set, which shows that the first two are kept while V is cleared. Directed sequences then check that the interrupt-accept clear beats a set command or a write in the same cycle, and that the gating responds to mixed pending and enable patterns.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [1:0] {
    ALU_NONE  = 2'd0,
    ALU_ADD   = 2'd1,
    ALU_SUB   = 2'd2,
    ALU_LOGIC = 2'd3
  } alu_op_e;

  localparam int unsigned PSR_W = 8;
  localparam int unsigned B_I = 7;
  localparam int unsigned B_T = 6;
  localparam int unsigned B_H = 5;
  localparam int unsigned B_S = 4;
  localparam int unsigned B_V = 3;
  localparam int unsigned B_N = 2;
  localparam int unsigned B_Z = 1;
  localparam int unsigned B_C = 0;

  typedef struct packed {
    logic h;
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/psr_alu_flags.sv
module psr_alu_flags
  import psr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e           op_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  input  logic [DW-1:0]     lres_i,
  output logic [DW-1:0]     res_o,
  output alu_flags_t        flags_o
);
  localparam int unsigned HALF = DW / 2;

  logic [DW:0]   full;
  logic [HALF:0] half;
  logic          sa, sb, sr;

  always_comb begin
    unique case (op_i)
      ALU_ADD: begin
        full = {1'b0, a_i} + {1'b0, b_i};
        half = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]};
      end
      ALU_SUB: begin
        full = {1'b0, a_i} - {1'b0, b_i};
        half = {1'b0, a_i[HALF-1:0]} - {1'b0, b_i[HALF-1:0]};
      end
      ALU_LOGIC: begin
        full = {1'b0, lres_i};
        half = '0;
      end
      default: begin
        full = '0;
        half = '0;
      end
    endcase
  end

  assign res_o = full[DW-1:0];
  assign sa    = a_i[DW-1];
  assign sb    = b_i[DW-1];
  assign sr    = full[DW-1];

  always_comb begin
    flags_o.c = full[DW];
    flags_o.h = half[HALF];
    flags_o.n = sr;
    flags_o.z = ~|full[DW-1:0];
    unique case (op_i)
      ALU_ADD: flags_o.v = (sa == sb) && (sr != sa);
      ALU_SUB: flags_o.v = (sa != sb) && (sr != sa);
      default: flags_o.v = 1'b0;
    endcase
  end
endmodule

// File: rtl/psr_bit_copy.sv
module psr_bit_copy #(
  parameter int unsigned DW = 8,
  localparam int unsigned SW = $clog2(DW)
) (
  input  logic [DW-1:0] reg_op_i,
  input  logic [SW-1:0] sel_i,
  input  logic          t_i,
  output logic          bit_o,
  output logic [DW-1:0] ld_res_o
);
  assign bit_o = reg_op_i[sel_i];

  for (genvar g = 0; g < DW; g++) begin : g_ld
    assign ld_res_o[g] = (sel_i == SW'(g)) ? t_i : reg_op_i[g];
  end
endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
  parameter int unsigned NUM_IRQ = 4
) (
  input  logic               ie_i,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  output logic [NUM_IRQ-1:0] req_o
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
    assign req_o[g] = ie_i & pend_i[g] & en_i[g];
  end
endmodule

// File: rtl/proc_status_reg.sv
module proc_status_reg
  import psr_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned NUM_IRQ = 4,
  localparam int unsigned SW     = $clog2(DW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         alu_op_i,
  input  logic [DW-1:0]      opa_i,
  input  logic [DW-1:0]      opb_i,
  input  logic [DW-1:0]      logic_res_i,
  output logic [DW-1:0]      arith_res_o,
  input  logic               wr_en_i,
  input  logic [PSR_W-1:0]   wr_data_i,
  input  logic               sei_i,
  input  logic               cli_i,
  input  logic               reti_i,
  input  logic               irq_ack_i,
  input  logic               bst_i,
  input  logic [SW-1:0]      bit_sel_i,
  input  logic [DW-1:0]      reg_op_i,
  output logic [DW-1:0]      bld_res_o,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  output logic [NUM_IRQ-1:0] irq_req_o,
  output logic [PSR_W-1:0]   status_o
);
  alu_op_e            op;
  alu_flags_t         fl;
  logic               st_bit;
  logic [PSR_W-1:0]   psr_q, psr_d;

  assign op = alu_op_e'(alu_op_i);

  psr_alu_flags #(.DW(DW)) i_flags (
    .op_i    (op),
    .a_i     (opa_i),
    .b_i     (opb_i),
    .lres_i  (logic_res_i),
    .res_o   (arith_res_o),
    .flags_o (fl)
  );

  psr_bit_copy #(.DW(DW)) i_bitcopy (
    .reg_op_i (reg_op_i),
    .sel_i    (bit_sel_i),
    .t_i      (psr_q[B_T]),
    .bit_o    (st_bit),
    .ld_res_o (bld_res_o)
  );

  psr_irq_gate #(.NUM_IRQ(NUM_IRQ)) i_gate (
    .ie_i   (psr_q[B_I]),
    .pend_i (irq_pend_i),
    .en_i   (irq_en_i),
    .req_o  (irq_req_o)
  );

  // Precedence: write < flag update < bit store < enable commands < acceptance
  always_comb begin
    psr_d = psr_q;
    if (wr_en_i) begin
      psr_d      = wr_data_i;
      psr_d[B_S] = wr_data_i[B_N] ^ wr_data_i[B_V];
    end
    if (op != ALU_NONE) begin
      if (op != ALU_LOGIC) begin
        psr_d[B_H] = fl.h;
        psr_d[B_C] = fl.c;
      end
      psr_d[B_V] = fl.v;
      psr_d[B_N] = fl.n;
      psr_d[B_Z] = fl.z;
      psr_d[B_S] = fl.n ^ fl.v;
    end
    if (bst_i)           psr_d[B_T] = st_bit;
    if (sei_i || reti_i) psr_d[B_I] = 1'b1;
    if (cli_i)           psr_d[B_I] = 1'b0;
    if (irq_ack_i)       psr_d[B_I] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psr_q <= '0;
    else         psr_q <= psr_d;
  end

  assign status_o = psr_q;

  a_r3_sign_xor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[B_S] == (status_o[B_N] ^ status_o[B_V]));

  a_r9_ack_clears_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> !status_o[B_I]);

  a_r8_sei_sets_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sei_i && !cli_i && !irq_ack_i) |=> status_o[B_I]);

  a_r7_gate_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[B_I] |-> (irq_req_o == '0));

  a_r6_logic_keeps_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == ALU_LOGIC && !wr_en_i) |=> ($stable(status_o[B_C]) && $stable(status_o[B_H])));

  a_r12_bld_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(bld_res_o ^ reg_op_i) <= 1);
endmodule

// File: tb/test_proc_status_reg.sv
module test_proc_status_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] alu_op_i = '0;
  logic [7:0] opa_i = '0, opb_i = '0, logic_res_i = '0, arith_res_o;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       sei_i = 1'b0, cli_i = 1'b0, reti_i = 1'b0, irq_ack_i = 1'b0, bst_i = 1'b0;
  logic [2:0] bit_sel_i = '0;
  logic [7:0] reg_op_i = '0, bld_res_o;
  logic [3:0] irq_pend_i = '0, irq_en_i = '0, irq_req_o;
  logic [7:0] status_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  proc_status_reg i_proc_status_reg (
    .clk_i, .rst_ni, .alu_op_i, .opa_i, .opb_i, .logic_res_i, .arith_res_o,
    .wr_en_i, .wr_data_i, .sei_i, .cli_i, .reti_i, .irq_ack_i, .bst_i,
    .bit_sel_i, .reg_op_i, .bld_res_o, .irq_pend_i, .irq_en_i, .irq_req_o,
    .status_o
  );

  // {op, a (logic result for op 3), b, preset, expected status}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {2'd1, 8'h01, 8'h01, 8'hC0, 8'hC0},
    {2'd1, 8'h0F, 8'h01, 8'h00, 8'h20},
    {2'd1, 8'h7F, 8'h01, 8'h00, 8'h2C},
    {2'd1, 8'hFF, 8'h01, 8'h00, 8'h23},
    {2'd1, 8'h80, 8'h80, 8'h00, 8'h1B},
    {2'd2, 8'h05, 8'h03, 8'h3F, 8'h00},
    {2'd2, 8'h03, 8'h05, 8'h00, 8'h35},
    {2'd2, 8'h80, 8'h01, 8'h00, 8'h38},
    {2'd2, 8'h42, 8'h42, 8'h00, 8'h02},
    {2'd2, 8'h10, 8'h01, 8'h00, 8'h20},
    {2'd3, 8'h00, 8'h00, 8'h29, 8'h23},
    {2'd3, 8'h80, 8'h00, 8'h00, 8'h14},
    {2'd3, 8'h80, 8'h00, 8'hE1, 8'hF5},
    {2'd3, 8'h5A, 8'h00, 8'h1E, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    alu_op_i = '0; wr_en_i = 0; sei_i = 0; cli_i = 0; reti_i = 0;
    irq_ack_i = 0; bst_i = 0;
  endtask

  // apply current inputs for one edge, then idle and sample at the next falling edge
  task automatic tick();
    @(negedge clk_i);
    idle();
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en_i = 1; wr_data_i = v;
    tick();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    chk("R1 reset", status_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] a, b, pre, exp;
      string      rq;
      {op, a, b, pre, exp} = VEC[i];
      rq = (op == 2'd1) ? "R4 add" : (op == 2'd2) ? "R5 sub" : "R6 logic";
      wr(pre);
      alu_op_i = op; opa_i = a; opb_i = b; logic_res_i = a;
      tick();
      chk(rq, status_o, exp);
      chk("R3 sign", {7'd0, status_o[4]}, {7'd0, status_o[2] ^ status_o[3]});
    end

    // R2 software write, S derived from N and V
    wr(8'hB5);
    chk("R2 write", status_o, 8'hB5);
    wr(8'h1C);
    chk("R2 write S from N^V", status_o, 8'h0C);

    // R8 set/clear commands
    wr(8'h00);
    sei_i = 1; tick();
    chk("R8 sei", status_o, 8'h80);
    cli_i = 1; tick();
    chk("R8 cli", status_o, 8'h00);
    sei_i = 1; cli_i = 1; tick();
    chk("R8 cli wins", status_o, 8'h00);

    // R7 gating
    irq_pend_i = 4'hF; irq_en_i = 4'hF;
    @(negedge clk_i);
    chk("R7 gate closed", {4'd0, irq_req_o}, 8'h00);
    sei_i = 1; tick();
    irq_pend_i = 4'b1011; irq_en_i = 4'b0110;
    #1;
    chk("R7 gate open", {4'd0, irq_req_o}, 8'h02);

    // R9 acceptance and return
    irq_ack_i = 1; tick();
    chk("R9 ack clears I", status_o, 8'h00);
    chk("R7 gate after ack", {4'd0, irq_req_o}, 8'h00);
    reti_i = 1; tick();
    chk("R9 reti sets I", status_o, 8'h80);

    // R10 acceptance wins
    cli_i = 1; tick();
    irq_ack_i = 1; sei_i = 1; tick();
    chk("R10 ack vs sei", status_o, 8'h00);
    irq_ack_i = 1; reti_i = 1; tick();
    chk("R10 ack vs reti", status_o, 8'h00);
    irq_ack_i = 1; wr_en_i = 1; wr_data_i = 8'hFF; tick();
    chk("R10 ack vs write", status_o, 8'h6F);

    // R11 bit store
    wr(8'h00);
    bst_i = 1; reg_op_i = 8'h20; bit_sel_i = 3'd5; tick();
    chk("R11 bst one", status_o, 8'h40);
    bst_i = 1; reg_op_i = 8'hEF; bit_sel_i = 3'd4; tick();
    chk("R11 bst zero", status_o, 8'h00);

    // R12 bit load
    wr(8'h40);
    reg_op_i = 8'h00; bit_sel_i = 3'd3; #1;
    chk("R12 bld set", bld_res_o, 8'h08);
    wr(8'h00);
    reg_op_i = 8'hFF; bit_sel_i = 3'd7; #1;
    chk("R12 bld clear", bld_res_o, 8'h7F);

    // R1 reset clears everything again
    wr(8'hFF);
    rst_ni = 1'b0; #1;
    chk("R1 async reset", status_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule